// File: doc/BRIEF.md
# Rotate-and-Mix Pseudo-Random Word Generator

This block returns a fresh 32-bit pseudo-random word each time a requester pulses a request strobe. It keeps 33 bits of state: a 32-bit word, which is also the output, and one extra top bit. Each advance does three things in order:

- It rotates the 33-bit value right by one place, passing through the extra bit.
- It xors the result with the old word shifted left by 12.
- It xors that intermediate value with itself shifted right by 20.

Started from any non-zero state, the sequence repeats only after 2^33 − 1 steps. The all-zero state is a fixed point, so the block refuses a zero seed.

A requester raises `next_i` for one cycle per word. On the following cycle `valid_o` pulses and the new word is on `rnd_o`, with the new top bit on `hi_o`. Both outputs hold until the next advance or seed load. A new seed can be written through `seed_lo_i`/`seed_hi_i` with `load_i`. The reset input is asynchronous and active low. Its release is synchronised inside the block, which costs two clock cycles before the state leaves reset.

Top module: `rng33_gen`

## Requirements
- R1: While reset is active, and after it, the state is word 0x55555555 with top bit 1, and `valid_o` is 0.
- R2: On an edge with `next_i`=1 and no accepted load, the new word is m ^ (m >> 20) (logical shift), where m = {old top bit, old word[31:1]} ^ (old word << 12). It appears on `rnd_o` one cycle after the request.
- R3: On an advance, the new top bit `hi_o` equals bit 0 of the previous word.
- R4: `valid_o` is 1 in the cycle after each edge where an advance took place, and 0 otherwise. A single request gives a one-cycle pulse; back-to-back requests give back-to-back pulses.
- R5: With neither `next_i` nor an accepted load, `rnd_o` and `hi_o` keep their values.
- R6: A load with a non-zero 33-bit seed {`seed_hi_i`,`seed_lo_i`} replaces the state. The seed is visible on `rnd_o`/`hi_o` one cycle later, and `valid_o` stays 0.
- R7: A non-zero load and a request on the same edge load the seed and do not advance.
- R8: A load whose seed is all 33 bits zero has no effect on the state. A request on that same edge advances as if no load were present.
- R9: The state is never all-zero.
- R10: From the reset seed, 10,000 consecutive advances reproduce the rotate-and-mix sequence exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| next_i | input | 1 | Request one new word |
| load_i | input | 1 | Load the seed inputs |
| seed_lo_i | input | 32 | Seed word |
| seed_hi_i | input | 1 | Seed top bit |
| rnd_o | output | 32 | Current random word |
| hi_o | output | 1 | Current top state bit |
| valid_o | output | 1 | One-cycle pulse after each advance |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. This covers the advanced word, the new top bit, the valid pulse and a loaded seed. The bench drives inputs on the falling edge, waits for the next rising edge, and samples 1 ns later, so each check reads the registered result of that single edge. Hold and ignored-load checks sample again one further edge later, before any new stimulus is applied. This shows that nothing changed. After reset is released, the bench waits out the two-cycle release synchroniser before it applies any stimulus.

// File: rtl/rng33_pkg.sv
package rng33_pkg;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic              hi;
    logic [WORD_W-1:0] lo;
  } rng_state_t;
endpackage

// File: rtl/rng33_rst_sync.sv
module rng33_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rng33_mix.sv
module rng33_mix
  import rng33_pkg::*;
#(
  parameter int unsigned SHL = 12,
  parameter int unsigned SHR = 20
) (
  input  rng_state_t cur_i,
  output rng_state_t nxt_o
);
  logic [WORD_W-1:0] rot, mid;

  always_comb begin
    // 33-bit rotate right through the top bit
    rot       = {cur_i.hi, cur_i.lo[WORD_W-1:1]};
    mid       = rot ^ (cur_i.lo << SHL);
    nxt_o.lo  = mid ^ (mid >> SHR);
    nxt_o.hi  = cur_i.lo[0];
  end
endmodule

// File: rtl/rng33_core.sv
module rng33_core
  import rng33_pkg::*;
#(
  parameter int unsigned     SHL     = 12,
  parameter int unsigned     SHR     = 20,
  parameter logic [WORD_W-1:0] SEED_LO = 32'h5555_5555,
  parameter logic            SEED_HI = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              next_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] seed_lo_i,
  input  logic              seed_hi_i,
  output rng_state_t        st_o,
  output logic              valid_o
);
  localparam rng_state_t RESET_ST = '{hi: SEED_HI, lo: SEED_LO};

  rng_state_t st_q, st_d, mixed, seed;
  logic       load_ok, step, st_en, vld_q, vld_d;

  rng33_mix #(.SHL(SHL), .SHR(SHR)) u_mix (.cur_i(st_q), .nxt_o(mixed));

  // next-state
  always_comb begin
    seed    = '{hi: seed_hi_i, lo: seed_lo_i};
    load_ok = load_i && (|seed);
    step    = next_i && !load_ok;
    st_en   = load_ok || step;
    st_d    = load_ok ? seed : mixed;
    vld_d   = step;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= RESET_ST;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign st_o    = st_q;
  assign valid_o = vld_q;

  p_valid_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (next_i && !load_ok) |=> valid_o);
  p_valid_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(next_i && !load_ok) |=> !valid_o);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!next_i && !load_i) |=> $stable(st_q));
  p_hi_from_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (next_i && !load_i) |=> (st_q.hi == $past(st_q.lo[0])));
  p_zero_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !next_i && seed_lo_i == '0 && !seed_hi_i) |=> $stable(st_q));
  p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (seed_lo_i != '0 || seed_hi_i)) |=>
      (st_q == $past({seed_hi_i, seed_lo_i}) && !valid_o));
  p_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != '0));
endmodule

// File: rtl/rng33_gen.sv
module rng33_gen
  import rng33_pkg::*;
#(
  parameter int unsigned       SHL       = 12,
  parameter int unsigned       SHR       = 20,
  parameter logic [WORD_W-1:0] SEED_LO   = 32'h5555_5555,
  parameter logic              SEED_HI   = 1'b1,
  parameter int unsigned       RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              next_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] seed_lo_i,
  input  logic              seed_hi_i,
  output logic [WORD_W-1:0] rnd_o,
  output logic              hi_o,
  output logic              valid_o
);
  logic       rst_sync_n;
  rng_state_t st;

  rng33_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  rng33_core #(
    .SHL(SHL), .SHR(SHR), .SEED_LO(SEED_LO), .SEED_HI(SEED_HI)
  ) u_core (
    .clk(clk), .rst_n(rst_sync_n), .next_i(next_i), .load_i(load_i),
    .seed_lo_i(seed_lo_i), .seed_hi_i(seed_hi_i),
    .st_o(st), .valid_o(valid_o)
  );

  assign rnd_o = st.lo;
  assign hi_o  = st.hi;
endmodule

// File: tb/rng33_gen_tb.sv
module rng33_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        next_i, load_i, seed_hi_i;
  logic [31:0] seed_lo_i;
  logic [31:0] rnd_o;
  logic        hi_o, valid_o;
  int          checks = 0;
  int          errors = 0;
  logic [32:0] ref_st;

  always #2.5 clk = ~clk;

  rng33_gen dut_i (
    .clk(clk), .rst_n(rst_n), .next_i(next_i), .load_i(load_i),
    .seed_lo_i(seed_lo_i), .seed_hi_i(seed_hi_i),
    .rnd_o(rnd_o), .hi_o(hi_o), .valid_o(valid_o)
  );

  function automatic logic [32:0] adv(input logic [32:0] s);
    logic [31:0] w, r, m;
    w = s[31:0];
    r = {s[32], w[31:1]};
    m = r ^ (w << 12);
    return {w[0], m ^ (m >> 20)};
  endfunction

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk); next_i = 0; load_i = 0; seed_lo_i = '0; seed_hi_i = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; next_i = 0; load_i = 0; seed_lo_i = '0; seed_hi_i = 0;
    repeat (3) @(posedge clk); #1;
    chk("R1 reset state", {hi_o, rnd_o}, {1'b1, 32'h5555_5555});
    chk("R1 reset valid", {32'b0, valid_o}, 33'd0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 state after release", {hi_o, rnd_o}, {1'b1, 32'h5555_5555});
    ref_st = {1'b1, 32'h5555_5555};
  endtask

  task automatic t_single_step();
    logic [32:0] old;
    old = {hi_o, rnd_o};
    @(negedge clk); next_i = 1;
    edge_sample();
    ref_st = adv(old);
    chk("R2 word", {1'b0, rnd_o}, {1'b0, ref_st[31:0]});
    chk("R3 top bit", {32'b0, hi_o}, {32'b0, old[0]});
    chk("R4 valid pulse", {32'b0, valid_o}, 33'd1);
    idle();
    edge_sample();
    chk("R4 pulse ends", {32'b0, valid_o}, 33'd0);
  endtask

  task automatic t_hold();
    idle();
    repeat (5) edge_sample();
    chk("R5 hold", {hi_o, rnd_o}, ref_st);
    chk("R5 no valid", {32'b0, valid_o}, 33'd0);
  endtask

  task automatic t_burst(input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); next_i = 1;
      edge_sample();
      ref_st = adv(ref_st);
      if ({hi_o, rnd_o} !== ref_st || valid_o !== 1'b1) begin
        bad++;
        if (bad < 4) chk("R10 burst step", {hi_o, rnd_o}, ref_st);
      end
    end
    if (bad == 0) chk("R10 burst final", {hi_o, rnd_o}, ref_st);
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R4/R10 burst mismatches actual=%0d expected=0", bad);
    end
    idle();
  endtask

  task automatic t_load(input logic hi, input logic [31:0] lo);
    @(negedge clk); load_i = 1; seed_hi_i = hi; seed_lo_i = lo;
    edge_sample();
    ref_st = {hi, lo};
    chk("R6 loaded", {hi_o, rnd_o}, ref_st);
    chk("R6 no valid", {32'b0, valid_o}, 33'd0);
    idle();
  endtask

  task automatic t_load_priority();
    @(negedge clk); load_i = 1; next_i = 1; seed_hi_i = 0; seed_lo_i = 32'hDEAD_BEEF;
    edge_sample();
    ref_st = {1'b0, 32'hDEAD_BEEF};
    chk("R7 load beats step", {hi_o, rnd_o}, ref_st);
    chk("R7 no valid", {32'b0, valid_o}, 33'd0);
    idle();
  endtask

  task automatic t_zero_seed();
    @(negedge clk); load_i = 1; seed_hi_i = 0; seed_lo_i = '0;
    edge_sample();
    chk("R8 zero seed ignored", {hi_o, rnd_o}, ref_st);
    chk("R9 state nonzero", {32'b0, ({hi_o, rnd_o} != 33'd0)}, 33'd1);
    @(negedge clk); load_i = 1; next_i = 1;
    edge_sample();
    ref_st = adv(ref_st);
    chk("R8 zero seed with step", {hi_o, rnd_o}, ref_st);
    chk("R8 step valid", {32'b0, valid_o}, 33'd1);
    idle();
  endtask

  initial begin
    t_reset();
    t_single_step();
    t_hold();
    t_single_step();
    t_load(1'b0, 32'h0000_0001);
    t_single_step();
    t_load(1'b1, 32'h0000_0000);
    t_single_step();
    t_load_priority();
    t_zero_seed();
    t_hold();
    t_reset();
    t_burst(10000);
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule